// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Slice with Group Carry Lookahead

This block is a purely combinational arithmetic and logic slice. It takes two 4-bit operands, a carry input and a 3-bit function code, and returns a 4-bit result. The function code selects one of three arithmetic operations, three bitwise operations, or one of two constant outputs. The arithmetic operations are an add and two subtracts, one for each operand order.

The slice has no carry output. Instead it drives an active-low group generate and an active-low group propagate. An external lookahead unit can combine these outputs from several slices to form the carry into each slice, so carries do not ripple from slice to slice. Inside the slice, each bit forms a propagate term and a generate term from the effective operands. For a subtract, the subtrahend is complemented before these terms are formed. All internal carries are computed in parallel, each as a sum of products of those terms.

Top module: `alu_slice_la`

## Requirements
- R1: Function code 000 drives the result to 0000 for every operand and carry-in value.
- R2: Function code 111 drives the result to 1111 for every operand and carry-in value.
- R3: Function code 011 gives result = (A + B + carryIn) mod 16.
- R4: Function code 001 gives result = (B - A - 1 + carryIn) mod 16.
- R5: Function code 010 gives result = (A - B - 1 + carryIn) mod 16.
- R6: Function codes 100, 101 and 110 give the bitwise XOR, OR and AND of A and B, in that order.
- R7: For codes 001, 010 and 011, grpGenN is low exactly when x + y > 15. Here (x, y) is (A, B) for 011, (B, not A) for 001, and (A, not B) for 010.
- R8: For codes 001, 010 and 011, grpPropN is low exactly when x + y equals 15, with the same (x, y) as in R7.
- R9: For codes 000, 100, 101, 110 and 111, grpGenN and grpPropN are both high.
- R10: For codes 000, 100, 101, 110 and 111, carryIn has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | Operand A |
| opB | input | 4 | Operand B |
| funcSel | input | 3 | Function code |
| carryIn | input | 1 | Carry into bit 0 |
| result | output | 4 | Function result |
| grpGenN | output | 1 | Group generate, active low |
| grpPropN | output | 1 | Group propagate, active low |

## Verification
For an arithmetic code, the result and the two group outputs come from the same propagate and generate terms and appear together. A wrong operand inversion can therefore corrupt both outputs at once, or corrupt only one of them. The bench applies every function code, every operand pair and both carry-in values. For each vector it compares the result against modular arithmetic. It also compares the group outputs against the overflow and all-ones conditions of the widened sum of the effective operands. Every mismatch is reported separately, so the bench shows which of the two paths failed.

// File: rtl/aluSlicePkg.sv
package aluSlicePkg;
  typedef enum logic [2:0] {
    SEL_CLEAR = 3'd0,
    SEL_BSUBA = 3'd1,
    SEL_ASUBB = 3'd2,
    SEL_ADD   = 3'd3,
    SEL_XOR   = 3'd4,
    SEL_OR    = 3'd5,
    SEL_AND   = 3'd6,
    SEL_SET   = 3'd7
  } aluSel_e;

  typedef enum logic [1:0] {
    LOG_XOR   = 2'd0,
    LOG_OR    = 2'd1,
    LOG_AND   = 2'd2,
    LOG_CONST = 2'd3
  } logicOp_e;

  typedef struct packed {
    logic     arith;
    logic     invA;
    logic     invB;
    logicOp_e logicOp;
    logic     constVal;
  } aluStrobe_t;
endpackage

// File: rtl/aluSliceCtrl.sv
module aluSliceCtrl
  import aluSlicePkg::*;
(
  input  logic [2:0] funcSel,
  output aluStrobe_t strb
);
  always_comb begin
    strb = '{arith: 1'b0, invA: 1'b0, invB: 1'b0, logicOp: LOG_CONST, constVal: 1'b0};
    unique case (aluSel_e'(funcSel))
      SEL_CLEAR: strb.constVal = 1'b0;
      SEL_BSUBA: begin strb.arith = 1'b1; strb.invA = 1'b1; end
      SEL_ASUBB: begin strb.arith = 1'b1; strb.invB = 1'b1; end
      SEL_ADD:   strb.arith = 1'b1;
      SEL_XOR:   strb.logicOp = LOG_XOR;
      SEL_OR:    strb.logicOp = LOG_OR;
      SEL_AND:   strb.logicOp = LOG_AND;
      SEL_SET:   strb.constVal = 1'b1;
      default:   strb.constVal = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown(funcSel)) begin
      AST_ONE_INVERT: assert (!(strb.invA && strb.invB)); // R4
      AST_INV_ONLY_ARITH: assert (strb.arith || !(strb.invA || strb.invB)); // R5
    end
  end
endmodule

// File: rtl/aluSliceDatapath.sv
module aluSliceDatapath
  import aluSlicePkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluStrobe_t       strb,
  output logic [WIDTH-1:0] result,
  output logic             grpGenN,
  output logic             grpPropN
);
  localparam int CW = WIDTH + 1;

  logic [WIDTH-1:0] xOp, yOp, prop, gen, arithSum;
  logic [CW-1:0]    carry;
  logic             grpGen, grpProp;

  assign xOp  = strb.invA ? ~opA : opA;
  assign yOp  = strb.invB ? ~opB : opB;
  assign prop = xOp ^ yOp;
  assign gen  = xOp & yOp;

  // each carry as a flat sum of products of generate/propagate terms
  always_comb begin
    carry = '0;
    carry[0] = carryIn;
    for (int i = 0; i < WIDTH; i++) begin
      logic pRun;
      logic term;
      pRun = 1'b1;
      term = 1'b0;
      for (int j = i; j >= 0; j--) begin
        term = term | (pRun & gen[j]);
        pRun = pRun & prop[j];
      end
      carry[i+1] = term | (pRun & carryIn);
    end
  end

  always_comb begin
    logic pRun;
    pRun   = 1'b1;
    grpGen = 1'b0;
    for (int j = WIDTH - 1; j >= 0; j--) begin
      grpGen = grpGen | (pRun & gen[j]);
      pRun   = pRun & prop[j];
    end
    grpProp = pRun;
  end

  assign arithSum = prop ^ carry[WIDTH-1:0];

  always_comb begin
    if (strb.arith) begin
      result = arithSum;
    end else begin
      unique case (strb.logicOp)
        LOG_XOR: result = opA ^ opB;
        LOG_OR:  result = opA | opB;
        LOG_AND: result = opA & opB;
        default: result = {WIDTH{strb.constVal}};
      endcase
    end
  end

  assign grpGenN  = strb.arith ? ~grpGen  : 1'b1;
  assign grpPropN = strb.arith ? ~grpProp : 1'b1;

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, strb})) begin
      if (strb.arith)
        AST_CARRY_MATCH_GROUP: assert (carry[WIDTH] == (grpGen | (grpProp & carryIn))); // R7
      if (!strb.arith)
        AST_GROUP_IDLE: assert (grpGenN && grpPropN); // R9
      if (!strb.arith && strb.logicOp == LOG_CONST && !strb.constVal)
        AST_CLEAR_ZERO: assert (result == '0); // R1
      if (!strb.arith && strb.logicOp == LOG_CONST && strb.constVal)
        AST_SET_ONES: assert (&result); // R2
      if (strb.arith && !strb.invA && !strb.invB)
        AST_ADD_SUM: assert (result == WIDTH'({1'b0, opA} + {1'b0, opB} + CW'(carryIn))); // R3
    end
  end
endmodule

// File: rtl/alu_slice_la.sv
module alu_slice_la
  import aluSlicePkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       funcSel,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             grpGenN,
  output logic             grpPropN
);
  aluStrobe_t strb;

  aluSliceCtrl u_ctrl (
    .funcSel (funcSel),
    .strb    (strb)
  );

  aluSliceDatapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .strb     (strb),
    .result   (result),
    .grpGenN  (grpGenN),
    .grpPropN (grpPropN)
  );
endmodule

// File: tb/alu_slice_la_tb.sv
module alu_slice_la_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opA = '0, opB = '0;
  logic [2:0] funcSel = '0;
  logic       carryIn = 1'b0;
  logic [3:0] result;
  logic       grpGenN, grpPropN;
  int         nChecks = 0, nFails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_slice_la u_dut (
    .opA(opA), .opB(opB), .funcSel(funcSel), .carryIn(carryIn),
    .result(result), .grpGenN(grpGenN), .grpPropN(grpPropN)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s sel=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               tag, funcSel, opA, opB, carryIn, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", result, 0);
    check("R9 reset", {grpGenN, grpPropN}, 3);
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int c = 0; c < 2; c++) begin
            int x, y, expF;
            string tF, tR;
            bit isArith;
            @(posedge clk);
            funcSel = 3'(s); opA = 4'(a); opB = 4'(b); carryIn = c[0];
            isArith = 1'b0; x = 0; y = 0;
            case (s)
              0: begin expF = 0; tF = "R1"; end
              1: begin x = b; y = 15 - a; isArith = 1; expF = (x + y + c) % 16; tF = "R4"; end
              2: begin x = a; y = 15 - b; isArith = 1; expF = (x + y + c) % 16; tF = "R5"; end
              3: begin x = a; y = b; isArith = 1; expF = (x + y + c) % 16; tF = "R3"; end
              4: begin expF = a ^ b; tF = "R6"; end
              5: begin expF = a | b; tF = "R6"; end
              6: begin expF = a & b; tF = "R6"; end
              default: begin expF = 15; tF = "R2"; end
            endcase
            @(negedge clk);
            if (!isArith && c == 1) tR = {tF, " R10"}; else tR = tF;
            check(tR, result, expF);
            if (isArith) begin
              check("R7 group generate", grpGenN, (x + y > 15) ? 0 : 1);
              check("R8 group propagate", grpPropN, (x + y == 15) ? 0 : 1);
            end else begin
              check("R9 group idle", {grpGenN, grpPropN}, 3);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule